// File: doc/BRIEF.md
# Comma-Aligned 20-Bit Serializer/Deserializer Core

This block is a digital model of a 20-bit serializer and deserializer pair that runs on a single bit-rate clock. On the transmit side, a free-running word-phase counter raises a one-cycle capture strobe once every 20 clocks. The parallel word present at the following edge is captured and then sent out one bit per clock, least significant bit first. On the receive side, incoming bits are shifted into a history register, and every 20 received bits are presented as one parallel word with a one-cycle valid strobe. A word-rate clock and its complement are also generated.

The receive word boundary can be re-established from the line. When alignment is enabled and a 7-bit comma pattern (either polarity) arrives, the receiver moves its boundary so that the first comma bit becomes bit 0 of the next output word. It flags that word with a sync pulse. When alignment is disabled, the boundary stays where it is. An internal loopback selects the transmitter's own serial output as the receive input, which lets a captured word return on the parallel receive port after a fixed delay.

Top module: `serdes20_core`

## Requirements
- R1: With `rst` high at a clock edge, the state is cleared synchronously: after that edge `rx_word`=0, `rx_valid`=0, `sync_flag`=0, `tx_serial_out`=0, `tx_load`=0, `rbc`=0 and `rbc_n`=1.
- R2: `tx_load` is a one-cycle pulse, high in the cycle after the 19th edge following reset release and then every 20 cycles. `tx_word` is captured only at the edge that ends a `tx_load` cycle, and its value at any other edge has no effect.
- R3: After the capture edge L, bit k of the captured word (k = 0..19) drives `tx_serial_out` in the cycle that follows edge L+k.
- R4: `rx_valid` is a one-cycle pulse, first raised by the 20th edge after reset release. With it, `rx_word` holds the last 20 received bits, with the earliest one in bit 0. `rx_word` changes only with `rx_valid`.
- R5: `rbc_n` is always the inverse of `rbc`. `rbc` is high whenever `rx_valid` is high, and stays high for the first half of each receive word period.
- R6: A comma is the 7-bit receive sequence 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0 (listed in arrival order). With `align_en`=1, the word that completes at the 13th edge after the edge sampling the comma's last bit carries the comma in `rx_word[6:0]`. Later words follow at 20-edge intervals.
- R7: `sync_flag` is high exactly in those `rx_valid` cycles whose `rx_word[6:0]` holds a comma, and only when `align_en` was 1 at the completing edge.
- R8: With `align_en`=0, a comma has no effect on the word boundary, and `sync_flag` stays low.
- R9: With `loopback_en`=1, the receiver takes `tx_serial_out` and ignores `rx_serial_in`. With `loopback_en`=0, it takes `rx_serial_in`.
- R10: In loopback, with the receive boundary on the transmit word boundary, a word captured at edge L appears on `rx_word` with `rx_valid` after edge L+20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| loopback_en | input | 1 | Route the transmit serial stream into the receiver |
| align_en | input | 1 | Allow comma-driven realignment of the receive boundary |
| tx_word | input | 20 | Parallel word to transmit |
| tx_load | output | 1 | High in the cycle whose closing edge captures `tx_word` |
| tx_serial_out | output | 1 | Serial transmit bit, LSB first |
| rx_serial_in | input | 1 | Serial receive bit from the line |
| rx_word | output | 20 | Received parallel word, earliest bit in bit 0 |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |
| sync_flag | output | 1 | Marks a word that starts with a comma |
| rbc | output | 1 | Receive word clock |
| rbc_n | output | 1 | Complement of `rbc` |

## Verification
Every result follows a fixed count of edges. A transmit bit appears one edge after capture plus its index. A receive word completes at the edge that samples its 20th bit, a realigned word at the 13th edge after the comma ends, and a loopback word 20 edges after its capture. The bench counts edges from its own counter. It records the capture edge from `tx_load`, maps each sampled edge to an index in the stream it generated, and reads outputs at the falling edge. Each expected word is therefore the block of stream bits ending at the edge just passed. The stream is built with no run longer than three equal bits, so a comma appears only where the bench inserted one.

// File: rtl/serdes20_pkg.sv
package serdes20_pkg;
    // Word width shared by the serial and parallel sides.
    localparam int unsigned WORD_W  = 20;
    // Comma length and pattern; bit i is the i-th bit on the line.
    localparam int unsigned COMMA_W = 7;
    localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/serdes20_tx.sv
module serdes20_tx #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word_i,
    output logic         load_o,
    output logic         ser_o
);
    localparam int unsigned PW = $clog2(W);
    localparam logic [PW-1:0] LAST = PW'(W - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic [W-1:0]  shreg;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic   at_last;

    assign at_last = (s_q.phase == LAST);

    always_comb begin
        s_d = s_q;
        if (at_last) begin
            s_d.phase = '0;
            s_d.shreg = word_i;                       // R2: capture on strobe only
        end else begin
            s_d.phase = s_q.phase + 1'b1;
            s_d.shreg = {1'b0, s_q.shreg[W-1:1]};     // R3: LSB leaves first
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign load_o = at_last;
    assign ser_o  = s_q.shreg[0];
endmodule

// File: rtl/serdes20_comma_det.sv
module serdes20_comma_det #(
    parameter int unsigned     K   = 7,
    parameter logic [K-1:0]    PAT = 7'b1111100
) (
    input  logic [K-1:0] win_i,
    output logic         hit_o
);
    logic [1:0] match;

    // Both running-disparity polarities of the comma.
    for (genvar p = 0; p < 2; p++) begin : g_pol
        localparam logic [K-1:0] REF = (p == 0) ? PAT : ~PAT;
        assign match[p] = (win_i == REF);
    end

    assign hit_o = |match;
endmodule

// File: rtl/serdes20_rx.sv
module serdes20_rx #(
    parameter int unsigned  W   = 20,
    parameter int unsigned  K   = 7,
    parameter logic [K-1:0] PAT = 7'b1111100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_i,
    input  logic         align_en,
    output logic [W-1:0] word_o,
    output logic         valid_o,
    output logic         sync_o,
    output logic         wclk_o,
    output logic         wclk_n_o
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] SEED = CW'(K);
    localparam logic [CW-1:0] HALF = CW'(W / 2);

    typedef struct packed {
        logic [W-1:0]  hist;
        logic [CW-1:0] cnt;
        logic [W-1:0]  word;
        logic          valid;
        logic          sync;
        logic          wclk;
        logic          wclk_n;
    } rx_st_t;

    rx_st_t       s_d, s_q;
    logic [W-1:0] hist_nx;
    logic         tail_hit, head_hit, wrap;

    // Newest bit enters at the top; bit 0 is the oldest.
    assign hist_nx = {bit_i, s_q.hist[W-1:1]};
    assign wrap    = (s_q.cnt == LAST);

    serdes20_comma_det #(.K(K), .PAT(PAT)) u_tail (
        .win_i (hist_nx[W-1:W-K]),
        .hit_o (tail_hit)
    );

    serdes20_comma_det #(.K(K), .PAT(PAT)) u_head (
        .win_i (hist_nx[K-1:0]),
        .hit_o (head_hit)
    );

    always_comb begin
        s_d       = s_q;
        s_d.hist  = hist_nx;
        s_d.valid = wrap;                             // R4
        s_d.sync  = 1'b0;
        if (wrap) begin
            s_d.word = hist_nx;
            s_d.sync = align_en & head_hit;           // R7
        end
        s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        // R6/R8: a fresh comma restarts the word with its K bits already in.
        if (align_en && tail_hit) s_d.cnt = SEED;
        s_d.wclk   = (s_d.cnt < HALF);                // R5
        s_d.wclk_n = ~(s_d.cnt < HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q        <= '0;                         // R1
            s_q.wclk_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o   = s_q.word;
    assign valid_o  = s_q.valid;
    assign sync_o   = s_q.sync;
    assign wclk_o   = s_q.wclk;
    assign wclk_n_o = s_q.wclk_n;
endmodule

// File: rtl/serdes20_core.sv
module serdes20_core
    import serdes20_pkg::*;
#(
    parameter int unsigned           W   = WORD_W,
    parameter int unsigned           K   = COMMA_W,
    parameter logic [COMMA_W-1:0]    PAT = COMMA_PAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         loopback_en,
    input  logic         align_en,
    input  logic [W-1:0] tx_word,
    output logic         tx_load,
    output logic         tx_serial_out,
    input  logic         rx_serial_in,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    output logic         sync_flag,
    output logic         rbc,
    output logic         rbc_n
);
    logic rx_bit;

    serdes20_tx #(.W(W)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .word_i (tx_word),
        .load_o (tx_load),
        .ser_o  (tx_serial_out)
    );

    // R9: internal loopback selects the transmitter's own stream.
    assign rx_bit = loopback_en ? tx_serial_out : rx_serial_in;

    serdes20_rx #(.W(W), .K(K), .PAT(PAT)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .bit_i    (rx_bit),
        .align_en (align_en),
        .word_o   (rx_word),
        .valid_o  (rx_valid),
        .sync_o   (sync_flag),
        .wclk_o   (rbc),
        .wclk_n_o (rbc_n)
    );
endmodule

// File: rtl/serdes20_core_chk.sv
module serdes20_core_chk #(
    parameter int unsigned W = 20
) (
    input logic         clk,
    input logic         rst,
    input logic         align_en,
    input logic         tx_load,
    input logic         tx_serial_out,
    input logic [W-1:0] rx_word,
    input logic         rx_valid,
    input logic         sync_flag,
    input logic         rbc,
    input logic         rbc_n
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    a_r1_reset_clear: assert property (@(posedge clk)
        (armed && $past(rst)) |-> (rx_word == '0 && !rx_valid && !sync_flag && !tx_serial_out && !tx_load));

    a_r2_load_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    a_r5_clock_pair: assert property (@(posedge clk) disable iff (rst)
        rbc_n == !rbc);

    a_r5_clock_high_on_word: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rbc);

    a_r7_sync_with_word: assert property (@(posedge clk) disable iff (rst)
        sync_flag |-> rx_valid);

    a_r7_sync_needs_align: assert property (@(posedge clk) disable iff (rst)
        sync_flag |-> $past(align_en));
endmodule

bind serdes20_core serdes20_core_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .align_en      (align_en),
    .tx_load       (tx_load),
    .tx_serial_out (tx_serial_out),
    .rx_word       (rx_word),
    .rx_valid      (rx_valid),
    .sync_flag     (sync_flag),
    .rbc           (rbc),
    .rbc_n         (rbc_n)
);

// File: tb/serdes20_core_test.sv
`timescale 1ns/1ps
module serdes20_core_test;
    localparam int W  = 20;
    localparam int NW = 14;
    localparam int NB = NW * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         loopback_en = 1'b1;
    logic         align_en = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         rx_serial_in = 1'b0;
    logic         tx_load, tx_serial_out, rx_valid, sync_flag, rbc, rbc_n;
    logic [W-1:0] rx_word;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    logic sb [NB];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serdes20_core uut (
        .clk           (clk),
        .rst           (rst),
        .loopback_en   (loopback_en),
        .align_en      (align_en),
        .tx_word       (tx_word),
        .tx_load       (tx_load),
        .tx_serial_out (tx_serial_out),
        .rx_serial_in  (rx_serial_in),
        .rx_word       (rx_word),
        .rx_valid      (rx_valid),
        .sync_flag     (sync_flag),
        .rbc           (rbc),
        .rbc_n         (rbc_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic bit is_comma(input logic [6:0] v);
        return (v == 7'b1111100) || (v == 7'b0000011);
    endfunction

    function automatic logic [W-1:0] word_of(input int w);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = sb[w*W + k];
        return r;
    endfunction

    // Stream with runs of at most three equal bits; optional comma inserted.
    task automatic build_stream(input int cpos, input bit neg);
        logic last = 1'b0;
        int   run = 0;
        for (int i = 0; i < NB; i++) begin
            logic b = 1'($urandom);
            if (i > 0 && run == 3 && b == last) b = ~last;
            if (i == 0 || b != last) run = 1; else run++;
            last = b;
            sb[i] = b;
        end
        if (cpos >= 0) begin
            sb[cpos-1] = neg ? 1'b0 : 1'b1;
            for (int k = 0; k < 7; k++) sb[cpos+k] = neg ^ (k >= 2);
            sb[cpos+7] = neg ? 1'b1 : 1'b0;
        end
    endtask

    // R1: reset clears state (also applied mid-run from a busy state).
    task automatic do_reset(input bit aen, input bit lb);
        @(negedge clk);
        rst = 1'b1;
        align_en = aen;
        loopback_en = lb;
        repeat (3) @(negedge clk);
        chk(rx_word == '0 && !rx_valid && !sync_flag, "R1 rx outputs cleared", {rx_word, rx_valid, sync_flag}, 32'h0);
        chk(!tx_serial_out && !tx_load, "R1 tx outputs cleared", {tx_serial_out, tx_load}, 32'h0);
        chk(!rbc && rbc_n, "R1 word clock pair reset", {rbc, rbc_n}, 32'h1);
        rst = 1'b0;
    endtask

    task automatic run_stream(input string tag, input int cpos, input bit neg, input bit aen, input bit lb);
        int  rel, l0, last_load, j0, w, idx;
        bit  have_l0, first_v, saw_al;
        logic [W-1:0] exp_w, wd;
        build_stream(cpos, neg);
        do_reset(aen, lb);
        rel = cyc;
        have_l0 = 0; first_v = 0; saw_al = 0; l0 = 0; last_load = 0;
        repeat (W * (NW + 2)) begin
            @(negedge clk);
            // R3: serial order of the transmitter
            if (have_l0 && cyc >= l0 && cyc - l0 < NB) begin
                idx = cyc - l0;
                chk(tx_serial_out == (lb ? sb[idx] : ~sb[idx]), "R3 serial bit order", 32'(tx_serial_out), 32'(lb ? sb[idx] : ~sb[idx]));
            end
            if (rx_valid) begin
                chk(rbc && !rbc_n, "R5 word clock high with word", {rbc, rbc_n}, 32'h2);
                if (!first_v) begin
                    chk(cyc == rel + W, "R4 first word after 20 edges", cyc - rel, W);
                    first_v = 1;
                end
                j0 = cyc - l0 - W;
                if (have_l0 && j0 >= 0 && j0 + W - 1 < NB) begin
                    for (int k = 0; k < W; k++) exp_w[k] = sb[j0 + k];
                    if (lb && j0 % W == 0)
                        chk(rx_word == exp_w, "R10 loopback latency word", rx_word, exp_w);
                    else
                        chk(rx_word == exp_w, lb ? "R4 received word" : "R9 external input word", rx_word, exp_w);
                    chk(sync_flag == (aen && is_comma(exp_w[6:0])), "R7 sync flag", 32'(sync_flag), 32'(aen && is_comma(exp_w[6:0])));
                    if (j0 == cpos) saw_al = 1;
                    if (!aen) chk(j0 % W == 0, "R8 boundary held", j0 % W, 0);
                end
            end
            // drive inputs for the next edge
            if (tx_load) begin
                if (!have_l0) begin
                    l0 = cyc + 1;
                    have_l0 = 1;
                    chk(l0 == rel + W, "R2 first capture edge", l0 - rel, W);
                end else begin
                    chk(cyc + 1 - last_load == W, "R2 capture spacing", cyc + 1 - last_load, W);
                end
                last_load = cyc + 1;
                w = (cyc + 1 - l0) / W;
                wd = (w < NW) ? word_of(w) : 20'hAAAAA;
                tx_word = lb ? wd : ((w < NW) ? ~wd : 20'hAAAAA);
            end else begin
                tx_word = 20'($urandom);           // R2: ignored off the strobe
            end
            idx = cyc - l0;
            if (lb) rx_serial_in = 1'($urandom);   // R9: ignored in loopback
            else if (!have_l0 || idx < 0) rx_serial_in = 1'b0;
            else if (idx < NB) rx_serial_in = sb[idx];
            else rx_serial_in = idx[0];
        end
        if (cpos >= 0 && aen)
            chk(saw_al, {"R6 comma aligned word seen: ", tag}, 32'(saw_al), 32'h1);
        if (cpos >= 0 && !aen)
            chk(!saw_al, {"R8 no realign when disabled: ", tag}, 32'(saw_al), 32'h0);
    endtask

    task automatic test_aligned_loopback;  run_stream("boundary", 100, 0, 1, 1); endtask
    task automatic test_offset_loopback;   run_stream("offset",    47, 0, 1, 1); endtask
    task automatic test_negative_comma;    run_stream("negative", 133, 1, 1, 1); endtask
    task automatic test_external_input;    run_stream("external",  93, 0, 1, 0); endtask
    task automatic test_align_disabled;    run_stream("disabled",  93, 0, 0, 1); endtask

    initial begin
        #(10 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_aligned_loopback();
        test_offset_loopback();
        test_negative_comma();
        test_external_input();
        test_align_disabled();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule